// File: doc/BRIEF.md
# Filtered Bus Bandwidth Statistics Collector

This block measures how many payload bytes move through two memory-port probes. Each probe presents at most one transaction event per cycle: a valid strobe, a write flag, an initiator ID and a payload byte count. A bank of counters adds up the bytes of the events it accepts, so software gets throughput by reading a counter twice and dividing the difference by the elapsed time.

Each counter chooses which probe it listens to. The first group of counters also applies a transaction-type filter and an initiator filter. The remaining counters take every event on their chosen probe. Counters stop at full scale and never wrap. They return to zero only when software stops the collector and starts it again.

A free-running timestamp, driven by a low-rate tick derived from the clock, can be read with one register access next to the counters. Software uses it to turn byte counts into bandwidth.

Top module: `bw_stat_collector`

## Requirements
- R1: Bit 0 of a counter's config word picks its source: 0 selects probe 0 and 1 selects probe 1. Events on the other probe never change that counter, even when they arrive in the same cycle.
- R2: On filtered counters, config bits [2:1] pick the transaction filter: 0 accepts reads only (write flag 0), 1 accepts writes only (write flag 1), and 2 or 3 accept both.
- R3: On filtered counters, config bit 3 set accepts any initiator. With bit 3 clear, only events whose initiator ID equals config bits [4+ID_W-1:4] are accepted. Counters NUM_FILT to NUM_CNT-1 ignore config bits above bit 0 and accept every valid event on their probe.
- R4: Each accepted event adds its payload byte count to the counter one clock later.
- R5: A counter saturates at all ones and never wraps. Bit i of the saturation register becomes 1 once counter i reaches all ones, and stays 1 until the next restart.
- R6: Bit 0 of the control register enables counting. While it is 0, the counters and saturation flags hold their values and events are ignored.
- R7: Writing 1 to control bit 0 while it is 0 zeroes every counter and saturation flag at that clock edge, and counting starts with the next cycle. Writing 1 while it is already 1 clears nothing.
- R8: Reads are combinational while reg_rd is high and return 0 otherwise. The map is: 0 = control, 1 = timestamp, 2 = saturation flags, 8+i = config of counter i, 16+i = value of counter i. Any other address reads 0. A counter read returns the value held in that cycle, even if an event is being added at the same edge.
- R9: The timestamp goes up by one every TS_DIV clock cycles from reset release and keeps running whatever the enable bit is.
- R10: After reset the enable bit, all configs, all counters, all saturation flags and the timestamp are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prb_valid | input | 2 | Event strobe, one bit per probe |
| prb_write | input | 2 | Write flag per probe (1 = write) |
| prb_init | input | 2*ID_W | Initiator ID per probe, probe p in bits [p*ID_W +: ID_W] |
| prb_bytes | input | 2*BYTES_W | Payload bytes per probe, probe p in bits [p*BYTES_W +: BYTES_W] |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The bench builds the collector with CNT_W=16, so a few hundred large events drive a counter into saturation and the sticky flag. With TS_DIV=8, several timestamp ticks fit inside a short run. NUM_CNT=8 and NUM_FILT=6 stay at their defaults, so both the filtered and the unfiltered counter variants are exercised against random configs and random event streams. Directed cases cover freezing, restart clearing, a re-enable that must not clear, and a read taken in the same cycle as an add.

// File: rtl/bwstat_pkg.sv
package bwstat_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    TF_RD   = 2'd0,
    TF_WR   = 2'd1,
    TF_ANY  = 2'd2,
    TF_ANY2 = 2'd3
  } tfilt_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_TIME = 5'd1;
  localparam logic [ADDR_W-1:0] A_SAT  = 5'd2;
  localparam logic [1:0]        PG_CFG = 2'b01;
  localparam logic [1:0]        PG_CNT = 2'b10;
endpackage

// File: rtl/bwstat_match.sv
module bwstat_match
  import bwstat_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int BYTES_W  = 8,
  parameter bit FILTERED = 1'b1,
  localparam int CFG_W   = 4 + ID_W
) (
  input  logic [CFG_W-1:0]     cfg,
  input  logic [1:0]           prb_valid,
  input  logic [1:0]           prb_write,
  input  logic [2*ID_W-1:0]    prb_init,
  input  logic [2*BYTES_W-1:0] prb_bytes,
  output logic                 hit,
  output logic [BYTES_W-1:0]   bytes
);
  logic              sel;
  logic              ev_v, ev_w, type_ok, id_ok;
  logic [ID_W-1:0]   ev_id;
  tfilt_e            tf;

  always_comb begin
    sel     = cfg[0];
    tf      = tfilt_e'(cfg[2:1]);
    ev_v    = prb_valid[sel];
    ev_w    = prb_write[sel];
    ev_id   = prb_init[sel*ID_W +: ID_W];
    bytes   = prb_bytes[sel*BYTES_W +: BYTES_W];
    case (tf)
      TF_RD:   type_ok = !ev_w;
      TF_WR:   type_ok = ev_w;
      default: type_ok = 1'b1;
    endcase
    id_ok   = cfg[3] || (ev_id == cfg[4 +: ID_W]);
    hit     = ev_v && (FILTERED ? (type_ok && id_ok) : 1'b1);
  end
endmodule

// File: rtl/bwstat_accum.sv
module bwstat_accum #(
  parameter int CNT_W   = 32,
  parameter int BYTES_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               run,
  input  logic               hit,
  input  logic [BYTES_W-1:0] bytes,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               sat_q
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             sat_d;

  always_comb begin
    sum   = {1'b0, cnt_q} + (CNT_W+1)'(bytes);
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (run && hit)
      cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    sat_d = (cnt_d == '1) || (sat_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sat_q <= sat_d;
    end
  end

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !sat_q);
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q) && $stable(sat_q));
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt_q >= $past(cnt_q));
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && !clr) |=> cnt_q == '1);
  p_sat_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !clr) |=> sat_q);
endmodule

// File: rtl/bwstat_stamp.sv
module bwstat_stamp #(
  parameter int TS_DIV = 3815,
  parameter int TS_W   = 32,
  localparam int DIV_W = $clog2(TS_DIV)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts_q
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [TS_W-1:0]  ts_d;
  logic             tick;

  always_comb begin
    tick  = (div_q == DIV_W'(TS_DIV - 1));
    div_d = tick ? '0 : div_q + 1'b1;
    ts_d  = tick ? ts_q + 1'b1 : ts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ts_q  <= '0;
    end else begin
      div_q <= div_d;
      ts_q  <= ts_d;
    end
  end

  p_ts_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ts_q == $past(ts_q)) || (ts_q == $past(ts_q) + 1'b1));
  p_ts_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ts_q != $past(ts_q));
endmodule

// File: rtl/bw_stat_collector.sv
module bw_stat_collector
  import bwstat_pkg::*;
#(
  parameter int NUM_CNT  = 8,
  parameter int NUM_FILT = 6,
  parameter int CNT_W    = 32,
  parameter int ID_W     = 4,
  parameter int BYTES_W  = 8,
  parameter int TS_DIV   = 3815,
  parameter int TS_W     = 32,
  localparam int CFG_W   = 4 + ID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           prb_valid,
  input  logic [1:0]           prb_write,
  input  logic [2*ID_W-1:0]    prb_init,
  input  logic [2*BYTES_W-1:0] prb_bytes,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [4:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata
);
  logic                   en_q, en_d, clr, wr_ctrl;
  logic [CFG_W-1:0]       cfg_q [NUM_CNT];
  logic [CFG_W-1:0]       cfg_d [NUM_CNT];
  logic [CNT_W-1:0]       cnt_arr [NUM_CNT];
  logic [NUM_CNT-1:0]     sat_vec;
  logic [TS_W-1:0]        ts;
  logic [2:0]             idx;
  logic                   unused_wbits;

  assign unused_wbits = ^reg_wdata[31:CFG_W];
  assign idx          = reg_addr[2:0];

  // control and config next state
  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    en_d    = wr_ctrl ? reg_wdata[0] : en_q;
    clr     = wr_ctrl && reg_wdata[0] && !en_q;
    for (int i = 0; i < NUM_CNT; i++) begin
      cfg_d[i] = cfg_q[i];
      if (reg_wr && reg_addr[4:3] == PG_CFG && int'(idx) == i)
        cfg_d[i] = reg_wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      for (int i = 0; i < NUM_CNT; i++) cfg_q[i] <= '0;
    end else begin
      en_q <= en_d;
      for (int i = 0; i < NUM_CNT; i++) cfg_q[i] <= cfg_d[i];
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic               hit;
    logic [BYTES_W-1:0] bytes;

    bwstat_match #(
      .ID_W(ID_W), .BYTES_W(BYTES_W), .FILTERED(g < NUM_FILT)
    ) u_match (
      .cfg(cfg_q[g]), .prb_valid(prb_valid), .prb_write(prb_write),
      .prb_init(prb_init), .prb_bytes(prb_bytes),
      .hit(hit), .bytes(bytes)
    );

    bwstat_accum #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .clr(clr), .run(en_q),
      .hit(hit), .bytes(bytes),
      .cnt_q(cnt_arr[g]), .sat_q(sat_vec[g])
    );
  end

  bwstat_stamp #(.TS_DIV(TS_DIV), .TS_W(TS_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .ts_q(ts)
  );

  // combinational read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == A_CTRL)
        reg_rdata[0] = en_q;
      else if (reg_addr == A_TIME)
        reg_rdata[TS_W-1:0] = ts;
      else if (reg_addr == A_SAT)
        reg_rdata[NUM_CNT-1:0] = sat_vec;
      else if (reg_addr[4:3] == PG_CFG && int'(idx) < NUM_CNT)
        reg_rdata[CFG_W-1:0] = cfg_q[idx];
      else if (reg_addr[4:3] == PG_CNT && int'(idx) < NUM_CNT)
        reg_rdata[CNT_W-1:0] = cnt_arr[idx];
    end
  end

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> en_q && (sat_vec == '0));
  p_idle_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_ctrl) |=> $stable(sat_vec));
endmodule

// File: tb/tb_bw_stat_collector.sv
module tb_bw_stat_collector;
  localparam int NUM_CNT  = 8;
  localparam int NUM_FILT = 6;
  localparam int CNT_W    = 16;
  localparam int ID_W     = 4;
  localparam int BYTES_W  = 8;
  localparam int TS_DIV   = 8;
  localparam int TS_W     = 32;
  localparam int CFG_W    = 4 + ID_W;
  localparam int unsigned MAXV = (1 << CNT_W) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [1:0]           prb_valid, prb_write;
  logic [2*ID_W-1:0]    prb_init;
  logic [2*BYTES_W-1:0] prb_bytes;
  logic                 reg_wr, reg_rd;
  logic [4:0]           reg_addr;
  logic [31:0]          reg_wdata, reg_rdata;

  int nvec = 0, nbad = 0;
  int unsigned cyc = 0;

  logic              m_en;
  logic [CFG_W-1:0]  m_cfg [NUM_CNT];
  int unsigned       m_cnt [NUM_CNT];
  logic              m_sat [NUM_CNT];

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  bw_stat_collector #(
    .NUM_CNT(NUM_CNT), .NUM_FILT(NUM_FILT), .CNT_W(CNT_W), .ID_W(ID_W),
    .BYTES_W(BYTES_W), .TS_DIV(TS_DIV), .TS_W(TS_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .prb_valid(prb_valid), .prb_write(prb_write),
    .prb_init(prb_init), .prb_bytes(prb_bytes), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic m_match(int i, int p);
    logic [CFG_W-1:0] c = m_cfg[i];
    if (!prb_valid[p]) return 1'b0;
    if (int'(c[0]) != p) return 1'b0;
    if (i >= NUM_FILT) return 1'b1;
    if (c[2:1] == 2'd0 && prb_write[p]) return 1'b0;
    if (c[2:1] == 2'd1 && !prb_write[p]) return 1'b0;
    if (!c[3] && prb_init[p*ID_W +: ID_W] != c[4 +: ID_W]) return 1'b0;
    return 1'b1;
  endfunction

  // one clock: model the edge from current inputs, then return at negedge
  task automatic step();
    logic clr;
    int unsigned nc [NUM_CNT];
    logic ns [NUM_CNT];
    clr = reg_wr && reg_addr == 5'd0 && reg_wdata[0] && !m_en;
    for (int i = 0; i < NUM_CNT; i++) begin
      nc[i] = m_cnt[i];
      ns[i] = m_sat[i];
      if (clr) begin
        nc[i] = 0; ns[i] = 1'b0;
      end else if (m_en) begin
        for (int p = 0; p < 2; p++)
          if (m_match(i, p)) begin
            nc[i] = nc[i] + prb_bytes[p*BYTES_W +: BYTES_W];
            if (nc[i] >= MAXV) begin nc[i] = MAXV; ns[i] = 1'b1; end
          end
      end
    end
    @(posedge clk);
    for (int i = 0; i < NUM_CNT; i++) begin
      m_cnt[i] = nc[i]; m_sat[i] = ns[i];
      if (reg_wr && reg_addr[4:3] == 2'b01 && int'(reg_addr[2:0]) == i)
        m_cfg[i] = reg_wdata[CFG_W-1:0];
    end
    if (reg_wr && reg_addr == 5'd0) m_en = reg_wdata[0];
    @(negedge clk);
    reg_wr = 1'b0;
    prb_valid = 2'b00;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic ev(input int p, input logic w, input int id, input int b);
    prb_valid[p] = 1'b1;
    prb_write[p] = w;
    prb_init[p*ID_W +: ID_W] = ID_W'(id);
    prb_bytes[p*BYTES_W +: BYTES_W] = BYTES_W'(b);
  endtask

  task automatic chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    nvec++;
    if (reg_rdata !== exp) begin
      nbad++;
      $display("FAIL %s addr %0d: got %0h expected %0h", req, a, reg_rdata, exp);
    end
    reg_rd = 1'b0;
  endtask

  task automatic chk_all(input string req);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      chk(5'(16 + i), m_cnt[i], req);
      s[i] = m_sat[i];
    end
    chk(5'd2, s, req);
  endtask

  task automatic rand_round(input int ncyc, input int idmax, input int bmax);
    for (int i = 0; i < NUM_CNT; i++) wr(5'(8 + i), $urandom() & ((1 << CFG_W) - 1) & 32'h3F);
    wr(5'd0, 0);
    wr(5'd0, 1);
    for (int c = 0; c < ncyc; c++) begin
      for (int p = 0; p < 2; p++)
        if ($urandom_range(9) < 6)
          ev(p, 1'($urandom_range(1)), $urandom_range(idmax), $urandom_range(bmax));
      step();
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    prb_valid = '0; prb_write = '0; prb_init = '0; prb_bytes = '0;
    m_en = 1'b0;
    for (int i = 0; i < NUM_CNT; i++) begin m_cfg[i] = '0; m_cnt[i] = 0; m_sat[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk(5'd0, 0, "R10");
    chk(5'd8, 0, "R10");
    chk_all("R10");
    chk(5'd20, 0, "R8 read strobe low check via addr");

    // R1 probe select, simultaneous events
    wr(5'd8, 32'h8 | 32'h4);          // ctr0: probe0, any type, any id
    wr(5'd9, 32'h8 | 32'h4 | 32'h1);  // ctr1: probe1
    wr(5'd0, 1);
    ev(0, 1'b0, 2, 10); ev(1, 1'b1, 3, 7); step();
    ev(1, 1'b0, 1, 5); step();
    chk(5'd16, 10, "R1 probe0 counter");
    chk(5'd17, 12, "R1 probe1 counter");

    // R8 read in same cycle as an add returns held value
    ev(0, 1'b0, 0, 33);
    chk(5'd16, 10, "R8 read before add");
    step();
    chk(5'd16, 43, "R4 add after edge");
    chk(5'd24, 0, "R8 unmapped address");

    // R2/R3/R4 random rounds
    for (int r = 0; r < 4; r++) begin
      rand_round(300, 3, 63);
      chk_all("R2 R3 R4 random");
    end

    // R6 freeze while disabled
    wr(5'd0, 0);
    for (int c = 0; c < 20; c++) begin ev(0, 1'b0, 1, 50); ev(1, 1'b1, 1, 50); step(); end
    chk_all("R6 freeze");
    chk(5'd0, 0, "R6 enable bit");

    // R7 restart clears; re-enable while running does not
    wr(5'd0, 1);
    chk_all("R7 restart");
    chk(5'd16, 0, "R7 counter zero");
    for (int c = 0; c < 10; c++) begin ev(0, 1'b0, 1, 9); step(); end
    wr(5'd0, 1);
    chk_all("R7 no clear when running");

    // R5 saturation on unfiltered counter 6 and filtered counter 0
    wr(5'd14, 32'hF6);                // unfiltered: upper bits must be ignored (R3)
    wr(5'd8, 32'h8 | 32'h4);
    wr(5'd0, 0);
    wr(5'd0, 1);
    for (int c = 0; c < 300; c++) begin ev(0, 1'b1, 5, 255); step(); end
    chk(5'd22, MAXV, "R5 saturate unfiltered");
    chk(5'd16, MAXV, "R5 saturate filtered");
    chk_all("R5 sticky flags");
    wr(5'd0, 0);
    wr(5'd0, 1);
    chk(5'd2, 0, "R5 flags cleared on restart");

    // R3 exact initiator match on a filtered counter
    wr(5'd10, 32'h4 | (32'd6 << 4)); // ctr2: probe0, both, id 6
    wr(5'd0, 0);
    wr(5'd0, 1);
    ev(0, 1'b0, 6, 20); step();
    ev(0, 1'b1, 5, 40); step();
    ev(0, 1'b1, 6, 3);  step();
    chk(5'd18, 23, "R3 initiator match");
    chk_all("R3 R2 final");

    // R9 timestamp
    chk(5'd1, cyc / TS_DIV, "R9 timestamp");
    repeat (37) step();
    chk(5'd1, cyc / TS_DIV, "R9 timestamp later");

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule